// File: doc/BRIEF.md
# Playback Sample Format Decoder

This block takes a single playback format byte and turns it into everything a playback path needs to know: the nominal sample rate in hertz, whether the stream is stereo, a byte-shift value for sizing transfer counts, and an error flag for settings it cannot serve. It then converts a byte stream into signed 16-bit linear samples according to the selected encoding. Unsigned 8-bit, mu-law, A-law, and signed 16-bit in either byte order are supported. The companding expansions are computed with shifts and adds, so no lookup table is stored.

The format byte is captured on a load strobe, together with a flag that widens the encoding field from two to three bits. Bytes arrive on a valid/ready input. Samples leave on a valid/ready output that holds one sample.

Top module: `pcm_fmt_decode`

## Requirements
- R1: After reset, the captured format is 0x00 with the narrow field. The block reports a rate of 8000, mono, a shift of 0 and no error. `out_valid` is low.
- R2: Format bit 0 picks the crystal table and bits 3:1 index it. Crystal 0 gives 8000, 16000, 27420, 32000, none, none, 48000 and 9000 Hz. Crystal 1 gives 5510, 11025, 18900, 22050, 37800, 44100, 33075 and 6620 Hz. A "none" entry reports a rate of 0 and sets the error flag.
- R3: Format bit 4 set means stereo and clear means mono. The shift is the stereo flag (0 or 1) for 8-bit and companded encodings. For 16-bit encodings the shift is 1 for mono and 2 for stereo.
- R4: The encoding code is format bits 7:5 when `wide_codes` is high at load. When it is low, only bits 6:5 are used and bit 7 is ignored. Code meanings: 0 unsigned 8-bit, 1 mu-law, 2 signed 16-bit low byte first, 3 A-law, 6 signed 16-bit high byte first.
- R5: Codes 4, 5 and 7 set the error flag. While the error flag is set, `in_ready` and `out_valid` stay low.
- R6: For code 0, each byte b yields the sample (b XOR 0x80) shifted left by 8.
- R7: For code 1, each byte yields the G.711 mu-law value. For example, 0x00 gives -32124, 0x80 gives +32124, and 0x7F and 0xFF give 0.
- R8: For code 3, each byte yields the G.711 A-law value. For example, 0x00 gives -5504 and 0x80 gives +5504; bytes below 0x80 are negative.
- R9: For 16-bit codes, two accepted bytes form one sample. Code 2 puts the first byte in bits 7:0, and code 6 puts the first byte in bits 15:8. The first byte alone produces no output.
- R10: A load takes effect one cycle later. In the load cycle `in_ready` is low. The load discards any half-assembled sample and any sample waiting at the output.
- R11: A sample presented with `out_ready` low stays valid and unchanged. `in_ready` stays low until the sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_load | input | 1 | Capture `fmt_byte` and `wide_codes` |
| fmt_byte | input | 8 | Format byte |
| wide_codes | input | 1 | Use a three-bit encoding field |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` |
| out_valid | output | 1 | Sample valid |
| out_sample | output | 16 | Signed 16-bit sample |
| out_ready | input | 1 | Downstream takes the sample |
| rate_hz | output | 16 | Selected rate in Hz, 0 when invalid |
| stereo | output | 1 | Stereo selected |
| shift | output | 2 | Byte shift for transfer counts |
| fmt_err | output | 1 | Format unusable |

## Verification
All 512 combinations of format byte and field width are swept. This catches a crystal table entry out of place, a missed error on the two empty rate slots, or bit 7 leaking into the code when the field is narrow; any of these would show up as a wrong rate or a spurious error. All 256 byte values are pushed through each of the mu-law, A-law and unsigned paths and compared with arithmetic references. A biasing or segment-shift slip would corrupt whole octaves of output there. The 16-bit tests cover byte order in both directions, and a reload after a lone first byte. A design that kept the stale half would swap the bytes of every following sample. Backpressure and the error state are checked for a dropped or altered sample and for a byte accepted while blocked.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;

    localparam int BYTE_W   = 8;
    localparam int SAMPLE_W = 16;
    localparam int RATE_W   = 16;
    localparam int SHIFT_W  = 2;

    typedef enum logic [2:0] {
        ENC_U8    = 3'd0,
        ENC_ULAW  = 3'd1,
        ENC_S16LE = 3'd2,
        ENC_ALAW  = 3'd3,
        ENC_RSV4  = 3'd4,
        ENC_ADPCM = 3'd5,
        ENC_S16BE = 3'd6,
        ENC_RSV7  = 3'd7
    } enc_e;

    typedef struct packed {
        logic [RATE_W-1:0]  rate_hz;
        logic               stereo;
        logic [SHIFT_W-1:0] shift;
        enc_e               enc;
        logic               err;
    } fmt_cfg_t;

    // Rate in Hz for a crystal select and a table index; 0 marks an empty slot.
    function automatic logic [RATE_W-1:0] rate_lookup(input logic xtal, input logic [2:0] idx);
        logic [RATE_W-1:0] r;
        if (!xtal) begin
            case (idx)
                3'd0: r = 16'd8000;
                3'd1: r = 16'd16000;
                3'd2: r = 16'd27420;
                3'd3: r = 16'd32000;
                3'd6: r = 16'd48000;
                3'd7: r = 16'd9000;
                default: r = '0;
            endcase
        end else begin
            case (idx)
                3'd0: r = 16'd5510;
                3'd1: r = 16'd11025;
                3'd2: r = 16'd18900;
                3'd3: r = 16'd22050;
                3'd4: r = 16'd37800;
                3'd5: r = 16'd44100;
                3'd6: r = 16'd33075;
                default: r = 16'd6620;
            endcase
        end
        return r;
    endfunction

    function automatic logic is_wide_enc(input enc_e e);
        return (e == ENC_S16LE) || (e == ENC_S16BE);
    endfunction

    function automatic logic is_bad_enc(input enc_e e);
        return (e == ENC_RSV4) || (e == ENC_ADPCM) || (e == ENC_RSV7);
    endfunction

    // G.711 mu-law: invert, rebuild the biased magnitude, remove the bias.
    function automatic logic [SAMPLE_W-1:0] ulaw_expand(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0]   u;
        logic [SAMPLE_W-1:0] mag;
        u   = ~b;
        mag = (({9'd0, u[3:0], 3'b000} + 16'd132) << u[6:4]) - 16'd132;
        return u[7] ? (16'd0 - mag) : mag;
    endfunction

    // G.711 A-law: undo even-bit toggling, then segment-scaled mantissa.
    function automatic logic [SAMPLE_W-1:0] alaw_expand(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0]   a;
        logic [SAMPLE_W-1:0] t;
        a = b ^ 8'h55;
        t = {8'd0, a[3:0], 4'b0000};
        if (a[6:4] == 3'd0)
            t = t + 16'd8;
        else
            t = (t + 16'h0108) << (a[6:4] - 3'd1);
        return a[7] ? t : (16'd0 - t);
    endfunction

endpackage

// File: rtl/fmt_cfg_reg.sv
module fmt_cfg_reg
    import pcm_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] fmt_in,
    input  logic              wide_in,
    output fmt_cfg_t          cfg
);
    logic [BYTE_W-1:0] fmt_q;
    logic              wide_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q  <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            fmt_q  <= fmt_in;
            wide_q <= wide_in;
        end
    end

    always_comb begin
        enc_e              code;
        logic [RATE_W-1:0] r;
        code = enc_e'({wide_q & fmt_q[7], fmt_q[6:5]});
        r    = rate_lookup(fmt_q[0], fmt_q[3:1]);
        cfg.rate_hz = r;
        cfg.stereo  = fmt_q[4];
        cfg.enc     = code;
        cfg.shift   = is_wide_enc(code) ? (fmt_q[4] ? 2'd2 : 2'd1) : {1'b0, fmt_q[4]};
        cfg.err     = is_bad_enc(code) || (r == '0);
    end
endmodule

// File: rtl/code_expand.sv
module code_expand
    import pcm_fmt_pkg::*;
(
    input  enc_e                enc,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic [SAMPLE_W-1:0] narrow_sample
);
    always_comb begin
        case (enc)
            ENC_ULAW: narrow_sample = ulaw_expand(byte_in);
            ENC_ALAW: narrow_sample = alaw_expand(byte_in);
            default:  narrow_sample = {byte_in ^ 8'h80, 8'h00};
        endcase
    end
endmodule

// File: rtl/sample_pack.sv
module sample_pack
    import pcm_fmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  enc_e                enc,
    input  logic                err,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic [SAMPLE_W-1:0] narrow_sample,
    output logic                in_ready,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    input  logic                out_ready
);
    logic              phase_q;
    logic [BYTE_W-1:0] hold_q;
    logic              accept;

    assign in_ready = !load && !err && (!out_valid || out_ready);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            phase_q    <= 1'b0;
            out_valid  <= 1'b0;
            hold_q     <= '0;
            out_sample <= '0;
        end else begin
            if (out_valid && out_ready)
                out_valid <= 1'b0;
            if (accept) begin
                if (is_wide_enc(enc)) begin
                    if (!phase_q) begin
                        hold_q  <= in_data;
                        phase_q <= 1'b1;
                    end else begin
                        out_sample <= (enc == ENC_S16BE) ? {hold_q, in_data} : {in_data, hold_q};
                        out_valid  <= 1'b1;
                        phase_q    <= 1'b0;
                    end
                end else begin
                    out_sample <= narrow_sample;
                    out_valid  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_fmt_decode.sv
module pcm_fmt_decode
    import pcm_fmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_load,
    input  logic [BYTE_W-1:0]   fmt_byte,
    input  logic                wide_codes,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    output logic                in_ready,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    input  logic                out_ready,
    output logic [RATE_W-1:0]   rate_hz,
    output logic                stereo,
    output logic [SHIFT_W-1:0]  shift,
    output logic                fmt_err
);
    fmt_cfg_t            cfg;
    logic [SAMPLE_W-1:0] narrow;

    fmt_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .load(fmt_load),
        .fmt_in(fmt_byte), .wide_in(wide_codes), .cfg(cfg)
    );

    code_expand u_exp (
        .enc(cfg.enc), .byte_in(in_data), .narrow_sample(narrow)
    );

    sample_pack u_pack (
        .clk(clk), .rst(rst), .load(fmt_load), .enc(cfg.enc), .err(cfg.err),
        .in_valid(in_valid), .in_data(in_data), .narrow_sample(narrow),
        .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample),
        .out_ready(out_ready)
    );

    assign rate_hz = cfg.rate_hz;
    assign stereo  = cfg.stereo;
    assign shift   = cfg.shift;
    assign fmt_err = cfg.err;
endmodule

// File: rtl/pcm_fmt_decode_chk.sv
module pcm_fmt_decode_chk (
    input logic        clk,
    input logic        rst,
    input logic        fmt_load,
    input logic        in_ready,
    input logic        out_valid,
    input logic [15:0] out_sample,
    input logic        out_ready,
    input logic [15:0] rate_hz,
    input logic        stereo,
    input logic [1:0]  shift,
    input logic        fmt_err
);
    // R2: a usable format always carries a nonzero rate
    a_r2_rate_nonzero: assert property (@(posedge clk) disable iff (rst)
        !fmt_err |-> rate_hz != 16'd0);

    // R3: a shift of two only arises from a stereo setting
    a_r3_shift_stereo: assert property (@(posedge clk) disable iff (rst)
        (shift == 2'd2) |-> stereo);

    // R5: nothing is emitted while the format is in error
    a_r5_err_silent: assert property (@(posedge clk) disable iff (rst)
        fmt_err |-> !out_valid);

    // R10: a load flushes the output
    a_r10_load_flush: assert property (@(posedge clk) disable iff (rst)
        fmt_load |=> !out_valid);

    // R11: a blocked sample stays put
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !fmt_load) |=> (out_valid && $stable(out_sample)));

    // R11: no byte taken while a sample waits
    a_r11_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind pcm_fmt_decode pcm_fmt_decode_chk u_chk (
    .clk(clk), .rst(rst), .fmt_load(fmt_load), .in_ready(in_ready),
    .out_valid(out_valid), .out_sample(out_sample), .out_ready(out_ready),
    .rate_hz(rate_hz), .stereo(stereo), .shift(shift), .fmt_err(fmt_err)
);

// File: tb/pcm_fmt_decode_tb.sv
`timescale 1ns/1ps
module pcm_fmt_decode_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_load = 1'b0;
    logic [7:0]  fmt_byte = '0;
    logic        wide_codes = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_sample;
    logic        out_ready = 1'b1;
    logic [15:0] rate_hz;
    logic        stereo;
    logic [1:0]  shift;
    logic        fmt_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcm_fmt_decode u_dut (
        .clk(clk), .rst(rst), .fmt_load(fmt_load), .fmt_byte(fmt_byte),
        .wide_codes(wide_codes), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample),
        .out_ready(out_ready), .rate_hz(rate_hz), .stereo(stereo),
        .shift(shift), .fmt_err(fmt_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_rate(input int f);
        int t0[8] = '{8000, 16000, 27420, 32000, 0, 0, 48000, 9000};
        int t1[8] = '{5510, 11025, 18900, 22050, 37800, 44100, 33075, 6620};
        return (f & 1) ? t1[(f >> 1) & 7] : t0[(f >> 1) & 7];
    endfunction

    function automatic int ref_ulaw(input int b);
        int u = (~b) & 255;
        int e = (u >> 4) & 7;
        int m = u & 15;
        int mag = ((2 * m + 33) << (e + 2)) - 132;
        return (u & 128) ? -mag : mag;
    endfunction

    function automatic int ref_alaw(input int b);
        int a = b ^ 85;
        int m = a & 15;
        int s = (a >> 4) & 7;
        int mag = (s == 0) ? 16 * m + 8 : (16 * m + 264) << (s - 1);
        return (a & 128) ? mag : -mag;
    endfunction

    task automatic load_fmt(input int f, input bit w);
        @(negedge clk);
        fmt_byte = f[7:0]; wide_codes = w; fmt_load = 1'b1;
        #1 chk(in_ready == 1'b0, "R10 ready low during load", int'(in_ready), 0);
        @(posedge clk); #1 fmt_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input int b);
        @(negedge clk);
        in_valid = 1'b1; in_data = b[7:0];
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic push_expect(input int b, input int exp, input string tag);
        push(b);
        chk(out_valid == 1'b1, tag, int'(out_valid), 1);
        chk(int'($signed(out_sample)) == exp, tag, int'($signed(out_sample)), exp);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rate_hz == 16'd8000, "R1 reset rate", int'(rate_hz), 8000);
        chk(stereo == 0 && shift == 0, "R1 reset mono/shift", int'(shift), 0);
        chk(fmt_err == 0 && out_valid == 0, "R1 reset err/valid", int'(fmt_err), 0);

        // R2 R3 R4 R5: sweep every format byte at both field widths
        for (int w = 0; w < 2; w++) begin
            for (int f = 0; f < 256; f++) begin
                int code, r, st, sh;
                bit bad;
                load_fmt(f, w[0]);
                code = w ? (f >> 5) & 7 : (f >> 5) & 3;
                r    = ref_rate(f);
                st   = (f >> 4) & 1;
                sh   = (code == 2 || code == 6) ? st + 1 : st;
                bad  = (code == 4 || code == 5 || code == 7 || r == 0);
                chk(int'(rate_hz) == r, "R2 rate", int'(rate_hz), r);
                chk(int'(stereo) == st && int'(shift) == sh, "R3 shift", int'(shift), sh);
                chk(fmt_err == bad, "R4 R5 error flag", int'(fmt_err), int'(bad));
                if (bad) chk(in_ready == 0 && out_valid == 0, "R5 blocked", int'(in_ready), 0);
            end
        end

        // R6 unsigned 8-bit
        load_fmt(8'h00, 1'b0);
        for (int b = 0; b < 256; b++)
            push_expect(b, int'($signed(16'((b ^ 128) << 8))), "R6 u8");
        // R7 mu-law
        load_fmt(8'h20, 1'b0);
        for (int b = 0; b < 256; b++) push_expect(b, ref_ulaw(b), "R7 ulaw");
        // R8 A-law
        load_fmt(8'h60, 1'b0);
        for (int b = 0; b < 256; b++) push_expect(b, ref_alaw(b), "R8 alaw");

        // R9 low byte first (also bit 7 ignored in the narrow field: 0xC0 -> code 2)
        load_fmt(8'hC0, 1'b0);
        for (int k = 0; k < 16; k++) begin
            int lo = (k * 37 + 5) & 255, hi = (k * 91 + 200) & 255;
            push(lo);
            chk(out_valid == 0, "R9 first byte silent", int'(out_valid), 0);
            push_expect(hi, int'($signed(16'((hi << 8) | lo))), "R9 le pair");
        end
        // R9 high byte first
        load_fmt(8'hC0, 1'b1);
        for (int k = 0; k < 16; k++) begin
            int hi = (k * 53 + 128) & 255, lo = (k * 29 + 3) & 255;
            push(hi);
            chk(out_valid == 0, "R9 first byte silent", int'(out_valid), 0);
            push_expect(lo, int'($signed(16'((hi << 8) | lo))), "R9 be pair");
        end

        // R10 reload drops a lone first byte
        push(8'hAA);
        load_fmt(8'h40, 1'b0);
        push(8'h34);
        chk(out_valid == 0, "R10 phase reset", int'(out_valid), 0);
        push_expect(8'h12, 16'h1234, "R10 after reload");

        // R11 backpressure
        load_fmt(8'h00, 1'b0);
        out_ready = 1'b0;
        push(8'h85);
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1 && out_sample == 16'h0500, "R11 held", int'(out_sample), 16'h0500);
            chk(in_ready == 0, "R11 stalled", int'(in_ready), 0);
        end
        // R10 reload discards a waiting sample
        load_fmt(8'h00, 1'b0);
        chk(out_valid == 0, "R10 output flushed", int'(out_valid), 0);
        out_ready = 1'b1;
        push_expect(8'h7F, -256, "R11 resume");

        // R5 error format blocks input
        load_fmt(8'h80, 1'b1);
        @(negedge clk); in_valid = 1'b1; in_data = 8'h11;
        repeat (3) begin
            @(negedge clk);
            chk(in_ready == 0 && out_valid == 0, "R5 error blocks", int'(out_valid), 0);
        end
        in_valid = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule